// File: doc/BRIEF.md
# Three-Term Karatsuba Polynomial Multiplier over GF(2^7)

This block takes two polynomials with three coefficients each and returns the five coefficients of their product. Every coefficient is an element of GF(2^7), the field built on x^7 + x + 1. The product is left unreduced, so it has degree up to four. Karatsuba-style sharing brings the work down to six coefficient products, where the schoolbook method needs nine. The outer coefficients come straight from the end products. The two neighbouring coefficients each come from one pair-sum product. The centre coefficient comes from the full-sum product and both pair-sum products, and the repeated a1·b1 terms cancel under XOR.

Operands enter on a valid/ready stream and results leave on another. One register stage sits between them. A word is accepted on any clock edge where `in_valid` and `in_ready` are both high. Its product appears on the output one clock later. The output word stays in place until the sink takes it with `out_ready`. While a result waits, `in_ready` is low, so back-pressure passes straight to the source. When `out_ready` is high, the stage accepts a new word in every cycle.

Top module: `kara3_mul`

## Requirements
- R1: The lowest output c0 equals a0·b0 and the highest output c4 equals a2·b2. Products are taken in GF(2^7) modulo x^7 + x + 1, and coefficient sums are bitwise XOR.
- R2: c1 equals a0·b1 + a1·b0.
- R3: c3 equals a1·b2 + a2·b1.
- R4: c2 equals a0·b2 + a1·b1 + a2·b0. This holds even though the datapath forms only six coefficient products.
- R5: A coefficient product whose raw degree reaches 7 or more is folded back using x^7 = x + 1. For example, 0x40 times 0x02 gives 0x03.
- R6: out_valid is high in the cycle after a word is accepted (in_valid and in_ready both high at a clock edge). out_valid falls after the sink takes the word, unless a new word is accepted on that same edge.
- R7: A synchronous reset clears out_valid, and any pending result is dropped.
- R8: in_ready is high exactly when the output register is empty or the sink is taking the word in that cycle. While out_valid is high and out_ready is low, in_ready is low.
- R9: While out_valid is high and out_ready is low, the outputs c0 to c4 and out_valid stay unchanged at the next clock.
- R10: A zero operand gives an all-zero product. Multiplying by the constant polynomial 1 (b0 = 1, b1 = b2 = 0) returns a0, a1 and a2 on c0, c1 and c2, with c3 = c4 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand word is present |
| in_ready | output | 1 | Block can take an operand word |
| a0 | input | 7 | Operand A, constant coefficient |
| a1 | input | 7 | Operand A, linear coefficient |
| a2 | input | 7 | Operand A, quadratic coefficient |
| b0 | input | 7 | Operand B, constant coefficient |
| b1 | input | 7 | Operand B, linear coefficient |
| b2 | input | 7 | Operand B, quadratic coefficient |
| out_valid | output | 1 | Product word is present |
| out_ready | input | 1 | Sink takes the product word |
| c0 | output | 7 | Product coefficient of x^0 |
| c1 | output | 7 | Product coefficient of x^1 |
| c2 | output | 7 | Product coefficient of x^2 |
| c3 | output | 7 | Product coefficient of x^3 |
| c4 | output | 7 | Product coefficient of x^4 |

## Verification
The bench builds the block with its default parameters: a coefficient width of 7 and a fold constant of 0x03, which encodes x^7 = x + 1. These are the only values the bench uses. With them, hand-picked operands can set the top input bits so that all six overflow bits of the raw product (x^7 through x^12) get folded back, and the bench compares each result against an independent shift-and-add field product. Random operands exercise every coefficient combination through the shared pair sums. Stretches of periodic sink stalls bring back-pressure within reach: held output words, a blocked `in_ready`, and a reset that arrives while a result is still waiting.

// File: rtl/kara3_pkg.sv
package kara3_pkg;
  // Number of coefficients per operand and in the unreduced product.
  localparam int TERMS_IN  = 3;
  localparam int TERMS_OUT = 2 * TERMS_IN - 1;
  // Six coefficient products: three single terms, two pair sums, one full sum.
  localparam int NUM_PROD  = 6;

  typedef enum logic [2:0] {
    P_LO   = 3'd0,
    P_MID  = 3'd1,
    P_HI   = 3'd2,
    P_LOW2 = 3'd3,
    P_UP2  = 3'd4,
    P_ALL  = 3'd5
  } prod_sel_e;
endpackage

// File: rtl/gf_coef_mul.sv
// Combinational multiply in GF(2^W): carry-less product, then fold the
// high bits back using x^W = FOLD (the low part of the field polynomial).
module gf_coef_mul #(
  parameter int W = 7,
  parameter logic [W-1:0] FOLD = 7'h03
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] p
);
  localparam int RAW_W = 2 * W - 1;

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] red;
  logic [RAW_W-1:0] x_ext;
  logic [RAW_W-1:0] fold_ext;

  assign x_ext    = {{(W-1){1'b0}}, x};
  assign fold_ext = {{(W-1){1'b0}}, FOLD};

  always_comb begin
    raw = '0;
    for (int i = 0; i < W; i++) begin
      if (y[i]) raw = raw ^ (x_ext << i);
    end
  end

  always_comb begin
    red = raw;
    for (int k = RAW_W - 1; k >= W; k--) begin
      if (red[k]) begin
        red[k] = 1'b0;
        red = red ^ (fold_ext << (k - W));
      end
    end
  end

  assign p = red[W-1:0];
endmodule

// File: rtl/kara3_presum.sv
// Shared operand sums for one side: the upper pair sum is reused for the full sum.
module kara3_presum #(
  parameter int W = 7
) (
  input  logic [W-1:0] t0,
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  output logic [W-1:0] s_low2,
  output logic [W-1:0] s_up2,
  output logic [W-1:0] s_all
);
  assign s_low2 = t0 ^ t1;
  assign s_up2  = t1 ^ t2;
  assign s_all  = s_up2 ^ t0;
endmodule

// File: rtl/kara3_combine.sv
// Recombines the six coefficient products into the five product coefficients.
module kara3_combine #(
  parameter int W = 7
) (
  input  logic [W-1:0] d_lo,
  input  logic [W-1:0] d_mid,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_low2,
  input  logic [W-1:0] d_up2,
  input  logic [W-1:0] d_all,
  output logic [W-1:0] k0,
  output logic [W-1:0] k1,
  output logic [W-1:0] k2,
  output logic [W-1:0] k3,
  output logic [W-1:0] k4
);
  assign k0 = d_lo;
  assign k1 = d_low2 ^ d_lo ^ d_mid;
  // The middle-square term enters three times and leaves one copy.
  assign k2 = d_all ^ d_low2 ^ d_up2;
  assign k3 = d_up2 ^ d_mid ^ d_hi;
  assign k4 = d_hi;
endmodule

// File: rtl/kara3_mul.sv
module kara3_mul #(
  parameter int COEF_W = 7,
  parameter logic [COEF_W-1:0] FIELD_POLY = 7'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] a0,
  input  logic [COEF_W-1:0] a1,
  input  logic [COEF_W-1:0] a2,
  input  logic [COEF_W-1:0] b0,
  input  logic [COEF_W-1:0] b1,
  input  logic [COEF_W-1:0] b2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] c0,
  output logic [COEF_W-1:0] c1,
  output logic [COEF_W-1:0] c2,
  output logic [COEF_W-1:0] c3,
  output logic [COEF_W-1:0] c4
);
  import kara3_pkg::*;

  logic [COEF_W-1:0] sa_low2, sa_up2, sa_all;
  logic [COEF_W-1:0] sb_low2, sb_up2, sb_all;
  logic [COEF_W-1:0] op_x [NUM_PROD];
  logic [COEF_W-1:0] op_y [NUM_PROD];
  logic [COEF_W-1:0] prod [NUM_PROD];
  logic [COEF_W-1:0] k0, k1, k2, k3, k4;
  logic [COEF_W-1:0] q0, q1, q2, q3, q4;
  logic              vld_q;
  logic              accept;

  kara3_presum #(.W(COEF_W)) u_sum_a (
    .t0(a0), .t1(a1), .t2(a2),
    .s_low2(sa_low2), .s_up2(sa_up2), .s_all(sa_all)
  );

  kara3_presum #(.W(COEF_W)) u_sum_b (
    .t0(b0), .t1(b1), .t2(b2),
    .s_low2(sb_low2), .s_up2(sb_up2), .s_all(sb_all)
  );

  assign op_x[P_LO]   = a0;      assign op_y[P_LO]   = b0;
  assign op_x[P_MID]  = a1;      assign op_y[P_MID]  = b1;
  assign op_x[P_HI]   = a2;      assign op_y[P_HI]   = b2;
  assign op_x[P_LOW2] = sa_low2; assign op_y[P_LOW2] = sb_low2;
  assign op_x[P_UP2]  = sa_up2;  assign op_y[P_UP2]  = sb_up2;
  assign op_x[P_ALL]  = sa_all;  assign op_y[P_ALL]  = sb_all;

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_prod
    gf_coef_mul #(.W(COEF_W), .FOLD(FIELD_POLY)) u_gmul (
      .x(op_x[g]), .y(op_y[g]), .p(prod[g])
    );
  end

  kara3_combine #(.W(COEF_W)) u_comb (
    .d_lo(prod[P_LO]), .d_mid(prod[P_MID]), .d_hi(prod[P_HI]),
    .d_low2(prod[P_LOW2]), .d_up2(prod[P_UP2]), .d_all(prod[P_ALL]),
    .k0(k0), .k1(k1), .k2(k2), .k3(k3), .k4(k4)
  );

  // A single output stage: free when empty or being drained this cycle.
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q0 <= k0;
      q1 <= k1;
      q2 <= k2;
      q3 <= k3;
      q4 <= k4;
    end
  end

  assign out_valid = vld_q;
  assign c0 = q0;
  assign c1 = q1;
  assign c2 = q2;
  assign c3 = q3;
  assign c4 = q4;
endmodule

// File: rtl/kara3_mul_chk.sv
module kara3_mul_chk #(
  parameter int COEF_W = 7,
  parameter logic [COEF_W-1:0] FIELD_POLY = 7'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [COEF_W-1:0] a0,
  input logic [COEF_W-1:0] a1,
  input logic [COEF_W-1:0] a2,
  input logic [COEF_W-1:0] b0,
  input logic [COEF_W-1:0] b1,
  input logic [COEF_W-1:0] b2,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] c0,
  input logic [COEF_W-1:0] c1,
  input logic [COEF_W-1:0] c2,
  input logic [COEF_W-1:0] c3,
  input logic [COEF_W-1:0] c4
);
  // Reference field product by shift-and-add (doubling with fold).
  function automatic logic [COEF_W-1:0] ref_mul(input logic [COEF_W-1:0] u,
                                                input logic [COEF_W-1:0] v);
    logic [COEF_W-1:0] acc, sh;
    acc = '0;
    sh  = u;
    for (int i = 0; i < COEF_W; i++) begin
      if (v[i]) acc = acc ^ sh;
      sh = sh[COEF_W-1] ? ({sh[COEF_W-2:0], 1'b0} ^ FIELD_POLY)
                        : {sh[COEF_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  logic [COEF_W-1:0] ref_c1, ref_c2;
  assign ref_c1 = ref_mul(a0, b1) ^ ref_mul(a1, b0);
  assign ref_c2 = ref_mul(a0, b2) ^ ref_mul(a1, b1) ^ ref_mul(a2, b0);

  a_r2_c1_schoolbook: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (c1 == $past(ref_c1)));

  a_r4_c2_schoolbook: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (c2 == $past(ref_c2)));

  a_r6_valid_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r6_valid_drops_when_drained: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r7_reset_clears_valid: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_empty_accepts: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(c0) && $stable(c1) && $stable(c2)
       && $stable(c3) && $stable(c4)));
endmodule

bind kara3_mul kara3_mul_chk #(.COEF_W(COEF_W), .FIELD_POLY(FIELD_POLY)) u_chk (.*);

// File: tb/kara3_mul_bench.sv
module kara3_mul_bench;
  localparam int W = 7;
  localparam logic [W-1:0] FOLD = 7'h03;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] a0 = '0, a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] c0, c1, c2, c3, c4;

  int n_checks = 0;
  int n_fail = 0;
  bit stall = 1'b0;
  int rdy_cnt = 0;
  bit done = 1'b0;

  logic [5*W-1:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  kara3_mul u_kara3_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a0(a0), .a1(a1), .a2(a2), .b0(b0), .b1(b1), .b2(b2),
    .out_valid(out_valid), .out_ready(out_ready),
    .c0(c0), .c1(c1), .c2(c2), .c3(c3), .c4(c4)
  );

  function automatic logic [W-1:0] gmul(input logic [W-1:0] u, input logic [W-1:0] v);
    logic [W-1:0] acc, sh;
    acc = '0;
    sh = u;
    for (int i = 0; i < W; i++) begin
      if (v[i]) acc ^= sh;
      sh = sh[W-1] ? ({sh[W-2:0], 1'b0} ^ FOLD) : {sh[W-2:0], 1'b0};
    end
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sink ready pattern, driven at the falling edge.
  always @(negedge clk) begin
    out_ready = stall ? (rdy_cnt % 3 == 0) : 1'b1;
    rdy_cnt++;
  end

  task automatic send(input logic [W-1:0] x0, x1, x2, y0, y1, y2, input string tag);
    logic [5*W-1:0] e;
    @(negedge clk);
    a0 = x0; a1 = x1; a2 = x2; b0 = y0; b1 = y1; b2 = y2;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e[W-1:0]     = gmul(x0, y0);
    e[2*W-1:W]   = gmul(x0, y1) ^ gmul(x1, y0);
    e[3*W-1:2*W] = gmul(x0, y2) ^ gmul(x1, y1) ^ gmul(x2, y0);
    e[4*W-1:3*W] = gmul(x1, y2) ^ gmul(x2, y1);
    e[5*W-1:4*W] = gmul(x2, y2);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Monitor: scoreboard compare on each transfer, plus stall rules.
  logic [5*W-1:0] held;
  bit was_stalled = 1'b0;
  always begin
    @(negedge clk);
    #2;
    if (rst) begin
      was_stalled = 1'b0;
    end else begin
      if (was_stalled) begin
        chk("R9 held valid", 64'(out_valid), 64'd1);
        chk("R9 held data", 64'({c4, c3, c2, c1, c0}), 64'(held));
      end
      if (out_valid && !out_ready) begin
        chk("R8 ready low under stall", 64'(in_ready), 64'd0);
        held = {c4, c3, c2, c1, c0};
        was_stalled = 1'b1;
      end else begin
        was_stalled = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R6 output without input", 64'd1, 64'd0);
        end else begin
          logic [5*W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk("R1 c0", 64'(c0), 64'(e[W-1:0]));
          chk("R2 c1", 64'(c1), 64'(e[2*W-1:W]));
          chk("R4 c2", 64'(c2), 64'(e[3*W-1:2*W]));
          chk("R3 c3", 64'(c3), 64'(e[4*W-1:3*W]));
          chk("R1 c4", 64'(c4), 64'(e[5*W-1:4*W]));
          if (t != "") chk(t, 64'({c4, c3, c2, c1, c0}), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset valid low", 64'(out_valid), 64'd0);
    chk("R8 ready while empty", 64'(in_ready), 64'd1);
    rst = 1'b0;

    // Latency: one word, then idle.
    send(7'h05, 7'h11, 7'h23, 7'h09, 7'h30, 7'h44, "");
    @(negedge clk); #1;
    chk("R6 valid one cycle after accept", 64'(out_valid), 64'd1);
    @(negedge clk); #1;
    chk("R6 valid falls after drain", 64'(out_valid), 64'd0);

    // Fold of x^7 and of the highest raw bits.
    send(7'h40, 7'h00, 7'h00, 7'h02, 7'h00, 7'h00, "R5 x^7 fold");
    send(7'h40, 7'h40, 7'h40, 7'h40, 7'h40, 7'h40, "R5 top-bit fold");
    send(7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F, "R5 all ones");
    // Zero and identity operands.
    send(7'h00, 7'h00, 7'h00, 7'h5A, 7'h33, 7'h71, "R10 zero operand");
    send(7'h1D, 7'h62, 7'h07, 7'h01, 7'h00, 7'h00, "R10 identity");
    // Single-term operands isolate each product position.
    send(7'h00, 7'h6B, 7'h00, 7'h00, 7'h00, 7'h35, "R3 single terms");
    send(7'h47, 7'h00, 7'h00, 7'h00, 7'h00, 7'h19, "R4 cross terms");

    // Back-to-back random words.
    for (int i = 0; i < 150; i++)
      send(W'($urandom), W'($urandom), W'($urandom),
           W'($urandom), W'($urandom), W'($urandom), "");

    // Random words under sink stalls.
    stall = 1'b1;
    for (int i = 0; i < 150; i++)
      send(W'($urandom), W'($urandom), W'($urandom),
           W'($urandom), W'($urandom), W'($urandom), "");
    stall = 1'b0;
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R6 every word delivered", 64'(exp_q.size()), 64'd0);

    // Reset with a result pending: hold the sink off, then reset.
    stall = 1'b1;
    send(7'h12, 7'h34, 7'h56, 7'h78, 7'h1A, 7'h2B, "");
    @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    @(negedge clk); #1;
    chk("R7 reset drops pending word", 64'(out_valid), 64'd0);
    rst = 1'b0;
    stall = 1'b0;
    @(negedge clk); #1;
    chk("R7 still empty after reset", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule